// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one channel of a direct memory access controller. It copies a block of bytes from a source address to a destination address over a simple request/ready bus, with no processor work during the copy. Software loads the two addresses, a byte count and a request-enable bit, and holds a set of control inputs steady. It then either pulses a start input, or lets a peripheral pulse a request line. The engine reports busy, done, a pending request, a configuration error and bus errors, and it drives an interrupt level.

The source and destination item sizes are chosen separately. When they differ, the engine packs or unpacks through a 32-bit holding register. It issues extra reads to build one wide write, or extra writes to drain one wide read. A group is the bytes of the wider item. Each address can stay fixed or step by its own item size, and can wrap inside an aligned power-of-two window, which makes a circular buffer.

The engine has two run modes. In run-to-completion mode one trigger runs groups back to back until the byte count is zero. In cycle-steal mode each trigger moves exactly one group and then lets go of the bus. A common use is a timer that paces a wave table into a converter register, one sample per request.

Top module: `dma_chan`

## Requirements
- R1: Size codes are 2'b00 = 4 bytes, 2'b01 = 1 byte, 2'b10 = 2 bytes, and 2'b11 is invalid. When the source item is wider than the destination item, one read feeds source/destination writes. The least significant bytes go out first, and data sits right-justified on `bus_rdata` and `bus_wdata`.
- R2: When the destination item is wider than the source item, destination/source reads are gathered into one write. The first read fills the least significant bytes.
- R3: After each accepted write, `bytes_left` drops by the destination item size. When it reaches zero, the channel goes idle and sets `done`. `irq` is high while `done` is set, `irq_en` is set and no error flag is set.
- R4: An address with its increment input set advances by its own item size after each accepted access. An address with its increment input clear is reused for every access.
- R5: A nonzero modulo value m keeps the stepping address inside its aligned window of 2^(m+3) bytes, wrapping to the window start. A value of zero disables wrapping.
- R6: With `steal_mode` low, one trigger runs every group back to back until `bytes_left` is zero. `bus_req` holds its address and direction until `bus_ready`.
- R7: With `steal_mode` high, each trigger moves one group and then drops `bus_req` while `busy` stays high. A peripheral request that arrives during a group, or in the same cycle as one is taken, is kept pending and served next.
- R8: `sw_start` triggers the channel whether `req_on` is set or not. `per_req` is honoured only while `req_on` is set, and otherwise neither moves data nor sets `pending`.
- R9: When `auto_off` is set, `req_on` clears as the byte count reaches zero.
- R10: A trigger makes no bus access and sets `cfg_err` and `done` if any of these holds: an address above 0xFFFFF, an invalid size code, an address misaligned to its item size, a zero count, or a count that is not a multiple of the group size.
- R11: An error response on a read sets `src_err` and `done`, and stops the channel with no further access.
- R12: An error response on a write sets `dst_err` and `done`, and stops the channel with no further access.
- R13: `done_clr` clears `done` and all three error flags.
- R14: `cfg_load` while `busy` is ignored: the addresses, count and `req_on` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load addresses, count and request enable (idle only) |
| cfg_src | input | 32 | Source start address |
| cfg_dst | input | 32 | Destination start address |
| cfg_count | input | CW | Byte count |
| cfg_req_en | input | 1 | Request-enable value to load |
| src_size | input | 2 | Source item size code |
| dst_size | input | 2 | Destination item size code |
| src_inc | input | 1 | Step the source address |
| dst_inc | input | 1 | Step the destination address |
| src_mod | input | 4 | Source wrap window code |
| dst_mod | input | 4 | Destination wrap window code |
| steal_mode | input | 1 | One group per trigger |
| auto_off | input | 1 | Clear request enable at completion |
| irq_en | input | 1 | Interrupt enable |
| sw_start | input | 1 | Software trigger pulse |
| per_req | input | 1 | Peripheral request pulse |
| done_clr | input | 1 | Clear done and error flags |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Access address |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | 32 | Write data, right-justified |
| bus_ready | input | 1 | Access accepted this cycle |
| bus_rdata | input | 32 | Read data, right-justified |
| bus_err | input | 1 | Error response with ready |
| busy | output | 1 | Channel active |
| done | output | 1 | Completed or stopped by error |
| pending | output | 1 | Peripheral request waiting |
| req_on | output | 1 | Request enable state |
| cfg_err | output | 1 | Configuration error |
| src_err | output | 1 | Read bus error |
| dst_err | output | 1 | Write bus error |
| irq | output | 1 | Completion interrupt |
| bytes_left | output | CW | Remaining byte count |

## Verification
Two events can meet in one cycle in cycle-steal mode. A new peripheral request can arrive in the same cycle the channel takes the pending one to start a group. The bench holds `per_req` high for two consecutive cycles while the channel is waiting, so the second cycle lands on the cycle that consumes the first request. It then expects two more groups to follow, with the count reaching zero and request enable cleared. Losing that second request would leave one group short. The same pattern also checks that a request latched while a group is in flight is served only once.

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int CW = 24,
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [31:0]   cfg_src,
  input  logic [31:0]   cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic          cfg_req_en,
  input  logic [1:0]    src_size,
  input  logic [1:0]    dst_size,
  input  logic          src_inc,
  input  logic          dst_inc,
  input  logic [3:0]    src_mod,
  input  logic [3:0]    dst_mod,
  input  logic          steal_mode,
  input  logic          auto_off,
  input  logic          irq_en,
  input  logic          sw_start,
  input  logic          per_req,
  input  logic          done_clr,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [31:0]   bus_wdata,
  input  logic          bus_ready,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_err,
  output logic          busy,
  output logic          done,
  output logic          pending,
  output logic          req_on,
  output logic          cfg_err,
  output logic          src_err,
  output logic          dst_err,
  output logic          irq,
  output logic [CW-1:0] bytes_left
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RD, S_WR} st_t;

  function automatic logic [2:0] nbytes(input logic [1:0] c);
    case (c)
      2'b00:   return 3'd4;
      2'b01:   return 3'd1;
      2'b10:   return 3'd2;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic misal(input logic [1:0] a, input logic [2:0] b);
    case (b)
      3'd2:    return a[0];
      3'd4:    return |a;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] bmask(input logic [2:0] b);
    case (b)
      3'd4:    return 32'hFFFF_FFFF;
      3'd2:    return 32'h0000_FFFF;
      3'd1:    return 32'h0000_00FF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [AW-1:0] wmask(input logic [3:0] md);
    if (md == 4'd0) return '1;
    return (AW'(1) << ({1'b0, md} + 5'd3)) - AW'(1);
  endfunction

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic inc,
                                         input logic [2:0] b, input logic [3:0] md);
    logic [AW-1:0] s, m;
    s = a + AW'(b);
    m = wmask(md);
    if (!inc) return a;
    return (a & ~m) | (s & m);
  endfunction

  st_t           st;
  logic [AW-1:0] sa, da;
  logic [CW-1:0] cnt;
  logic [31:0]   hold;
  logic [2:0]    off;
  logic          range_bad, req_en_q, pend_q, done_q, cerr_q, serr_q, derr_q;

  wire [2:0] sb  = nbytes(src_size);
  wire [2:0] db  = nbytes(dst_size);
  wire [2:0] gb  = (sb > db) ? sb : db;
  wire       hs  = bus_req & bus_ready;
  wire       go  = sw_start | pend_q;
  wire       pset = per_req & req_en_q;
  wire       rd_last = (off + sb) == gb;
  wire       wr_last = (off + db) == gb;
  wire       bad = range_bad | (sb == 3'd0) | (db == 3'd0) |
                   misal(sa[1:0], sb) | misal(da[1:0], db) |
                   (cnt == '0) | misal(cnt[1:0], gb);
  wire [AW-1:0] smask = wmask(src_mod);

  assign bus_req    = (st == S_RD) | (st == S_WR);
  assign bus_we     = (st == S_WR);
  assign bus_addr   = bus_we ? da : sa;
  assign bus_size   = bus_we ? dst_size : src_size;
  assign bus_wdata  = (hold >> {off, 3'b000}) & bmask(db);
  assign busy       = (st != S_IDLE);
  assign done       = done_q;
  assign pending    = pend_q;
  assign req_on     = req_en_q;
  assign cfg_err    = cerr_q;
  assign src_err    = serr_q;
  assign dst_err    = derr_q;
  assign irq        = done_q & irq_en & ~(cerr_q | serr_q | derr_q);
  assign bytes_left = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sa <= '0;
      da <= '0;
      cnt <= '0;
      hold <= '0;
      off <= '0;
      range_bad <= 1'b0;
      req_en_q <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      cerr_q <= 1'b0;
      serr_q <= 1'b0;
      derr_q <= 1'b0;
    end else begin
      if (done_clr) begin
        done_q <= 1'b0;
        cerr_q <= 1'b0;
        serr_q <= 1'b0;
        derr_q <= 1'b0;
      end
      if (pset) pend_q <= 1'b1;
      case (st)
        S_IDLE: begin
          if (cfg_load) begin
            sa <= cfg_src[AW-1:0];
            da <= cfg_dst[AW-1:0];
            cnt <= cfg_count;
            req_en_q <= cfg_req_en;
            range_bad <= (|cfg_src[31:AW]) | (|cfg_dst[31:AW]);
          end else if (go) begin
            if (bad) begin
              cerr_q <= 1'b1;
              done_q <= 1'b1;
              pend_q <= 1'b0;
            end else begin
              st <= S_RD;
              off <= '0;
              hold <= '0;
              pend_q <= pset;
            end
          end
        end
        S_WAIT: begin
          if (go) begin
            st <= S_RD;
            pend_q <= pset;
          end
        end
        S_RD: begin
          if (hs) begin
            if (bus_err) begin
              serr_q <= 1'b1;
              done_q <= 1'b1;
              pend_q <= 1'b0;
              st <= S_IDLE;
            end else begin
              hold <= hold | ((bus_rdata & bmask(sb)) << {off, 3'b000});
              sa <= step(sa, src_inc, sb, src_mod);
              if (rd_last) begin
                st <= S_WR;
                off <= '0;
              end else begin
                off <= off + sb;
              end
            end
          end
        end
        S_WR: begin
          if (hs) begin
            if (bus_err) begin
              derr_q <= 1'b1;
              done_q <= 1'b1;
              pend_q <= 1'b0;
              st <= S_IDLE;
            end else begin
              da <= step(da, dst_inc, db, dst_mod);
              cnt <= cnt - CW'(db);
              if (wr_last) begin
                off <= '0;
                hold <= '0;
                if (cnt == CW'(db)) begin
                  st <= S_IDLE;
                  done_q <= 1'b1;
                  pend_q <= 1'b0;
                  if (auto_off) req_en_q <= 1'b0;
                end else if (steal_mode) begin
                  st <= S_WAIT;
                end else begin
                  st <= S_RD;
                end
              end else begin
                off <= off + db;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we))); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && bus_we && !bus_err) |=> (bytes_left == $past(bytes_left) - CW'($past(db)))); // R3

  AST_WRAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !bus_we && !bus_err && src_inc && src_mod != 4'd0)
      |=> (((sa ^ $past(sa)) & ~$past(smask)) == '0)); // R5

  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && bus_we && !bus_err && steal_mode && wr_last && cnt != CW'(db))
      |=> (!bus_req && busy)); // R7

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> (!bus_req && !busy && done)); // R10

  AST_SRC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !bus_we && bus_err) |=> (!bus_req && src_err && done)); // R11

  AST_DST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && bus_we && bus_err) |=> (!bus_req && dst_err && done)); // R12

  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hs) |=> $stable(bytes_left)); // R14

endmodule

// File: tb/dma_chan_test.sv
module dma_chan_test;
  localparam int CW = 24;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cfg_load = 0, cfg_req_en = 0, src_inc = 1, dst_inc = 1;
  logic [31:0]   cfg_src = 0, cfg_dst = 0;
  logic [CW-1:0] cfg_count = 0;
  logic [1:0]    src_size = 0, dst_size = 0;
  logic [3:0]    src_mod = 0, dst_mod = 0;
  logic          steal_mode = 0, auto_off = 0, irq_en = 1, sw_start = 0, per_req = 0, done_clr = 0;
  logic          bus_req, bus_we, bus_ready, bus_err;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          busy, done, pending, req_on, cfg_err, src_err, dst_err, irq;
  logic [CW-1:0] bytes_left;

  logic [7:0]  smem [0:255];
  logic        stall_en = 0, tog = 0, err_en = 0, err_we = 0, clr_log = 0;
  logic [AW-1:0] err_addr = 0;
  logic [AW-1:0] wlog_a [0:63];
  logic [31:0]   wlog_d [0:63];
  logic [AW-1:0] rlog_a [0:63];
  int wr_n = 0, rd_n = 0;
  int nvec = 0, nbad = 0;
  logic finished = 0;

  dma_chan #(.CW(CW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_count(cfg_count), .cfg_req_en(cfg_req_en), .src_size(src_size), .dst_size(dst_size),
    .src_inc(src_inc), .dst_inc(dst_inc), .src_mod(src_mod), .dst_mod(dst_mod),
    .steal_mode(steal_mode), .auto_off(auto_off), .irq_en(irq_en), .sw_start(sw_start),
    .per_req(per_req), .done_clr(done_clr), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .busy(busy), .done(done), .pending(pending),
    .req_on(req_on), .cfg_err(cfg_err), .src_err(src_err), .dst_err(dst_err), .irq(irq),
    .bytes_left(bytes_left));

  wire [7:0] ra = bus_addr[7:0];
  assign bus_rdata = {smem[8'(ra + 8'd3)], smem[8'(ra + 8'd2)], smem[8'(ra + 8'd1)], smem[ra]};
  assign bus_ready = bus_req & (~stall_en | tog);
  assign bus_err   = bus_req & err_en & (bus_addr == err_addr) & (bus_we == err_we);

  always @(posedge clk) begin
    tog <= ~tog;
    if (clr_log) begin
      wr_n <= 0;
      rd_n <= 0;
    end else if (bus_req && bus_ready && !bus_err) begin
      if (bus_we) begin
        wlog_a[wr_n[5:0]] <= bus_addr;
        wlog_d[wr_n[5:0]] <= bus_wdata;
        wr_n <= wr_n + 1;
      end else begin
        rlog_a[rd_n[5:0]] <= bus_addr;
        rd_n <= rd_n + 1;
      end
    end
  end

  function automatic logic [31:0] word_at(input int a);
    return {smem[(a + 3) % 256], smem[(a + 2) % 256], smem[(a + 1) % 256], smem[a % 256]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] s, input logic [31:0] d, input int n, input logic re);
    @(negedge clk);
    cfg_src = s; cfg_dst = d; cfg_count = CW'(n); cfg_req_en = re; cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic kick();
    @(negedge clk); sw_start = 1;
    @(negedge clk); sw_start = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); done_clr = 1; clr_log = 1;
    @(negedge clk); done_clr = 0; clr_log = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic setmode(input logic [1:0] ss, input logic [1:0] ds, input logic si,
                         input logic di, input logic [3:0] sm, input logic st);
    src_size = ss; dst_size = ds; src_inc = si; dst_inc = di; src_mod = sm; dst_mod = 0;
    steal_mode = st;
  endtask

  task automatic t_reset();
    chk("R3 reset busy", {31'd0, busy}, 0);
    chk("R3 reset done", {31'd0, done}, 0);
    chk("R6 reset bus_req", {31'd0, bus_req}, 0);
    chk("R10 reset errs", {29'd0, cfg_err, src_err, dst_err}, 0);
  endtask

  task automatic t_word_copy();
    clear_all();
    setmode(2'b00, 2'b00, 1, 1, 0, 0);
    load(32'h00, 32'h80, 16, 0);
    kick(); wait_idle();
    chk("R6 word copy writes", wr_n, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R4 word copy addr", 32'(wlog_a[k]), 32'h80 + 32'(4 * k));
      chk("R6 word copy data", wlog_d[k], word_at(4 * k));
    end
    chk("R3 word copy left", 32'(bytes_left), 0);
    chk("R3 word copy done", {30'd0, done, busy}, 32'd2);
    chk("R3 word copy irq", {31'd0, irq}, 1);
  endtask

  task automatic t_unpack();
    clear_all();
    setmode(2'b00, 2'b01, 1, 1, 0, 0);
    load(32'h10, 32'h40, 8, 0);
    kick(); wait_idle();
    chk("R1 unpack reads", rd_n, 2);
    chk("R1 unpack writes", wr_n, 8);
    for (int k = 0; k < 8; k++) begin
      chk("R1 unpack byte", wlog_d[k], {24'd0, smem[16 + k]});
      chk("R4 unpack addr", 32'(wlog_a[k]), 32'h40 + 32'(k));
    end
  endtask

  task automatic t_pack();
    clear_all();
    setmode(2'b01, 2'b00, 1, 1, 0, 0);
    load(32'h20, 32'h60, 8, 0);
    kick(); wait_idle();
    chk("R2 pack reads", rd_n, 8);
    chk("R2 pack writes", wr_n, 2);
    chk("R2 pack word0", wlog_d[0], word_at(32'h20));
    chk("R2 pack word1", wlog_d[1], word_at(32'h24));
  endtask

  task automatic t_fixed_dst();
    clear_all();
    setmode(2'b00, 2'b10, 1, 0, 0, 0);
    load(32'h30, 32'h90, 8, 0);
    kick(); wait_idle();
    chk("R4 fixed writes", wr_n, 4);
    for (int k = 0; k < 4; k++)
      chk("R4 fixed addr", 32'(wlog_a[k]), 32'h90);
    chk("R1 half data", wlog_d[1], {16'd0, smem[8'h33], smem[8'h32]});
    chk("R1 half last", wlog_d[3], {16'd0, smem[8'h37], smem[8'h36]});
  endtask

  task automatic t_wrap();
    int exp_a [8] = '{8, 12, 0, 4, 8, 12, 0, 4};
    clear_all();
    stall_en = 1;
    setmode(2'b00, 2'b00, 1, 1, 4'd1, 0);
    load(32'h08, 32'hA0, 32, 0);
    kick(); wait_idle();
    stall_en = 0;
    chk("R5 wrap reads", rd_n, 8);
    for (int k = 0; k < 8; k++)
      chk("R5 wrap addr", 32'(rlog_a[k]), 32'(exp_a[k]));
    chk("R6 wrap stalled data", wlog_d[2], word_at(0));
  endtask

  task automatic t_steal();
    clear_all();
    setmode(2'b10, 2'b10, 1, 1, 0, 1);
    auto_off = 1;
    load(32'h00, 32'hB0, 6, 1);
    @(negedge clk); per_req = 1;
    @(negedge clk); per_req = 0;
    repeat (8) @(negedge clk);
    chk("R7 steal one group", wr_n, 1);
    chk("R7 steal left", 32'(bytes_left), 4);
    chk("R7 steal busy no bus", {30'd0, busy, bus_req}, 32'd2);
    load(32'h44, 32'h44, 100, 0);
    chk("R14 load while busy count", 32'(bytes_left), 4);
    chk("R14 load while busy req_on", {31'd0, req_on}, 1);
    @(negedge clk); per_req = 1;
    @(negedge clk);
    @(negedge clk); per_req = 0;
    repeat (14) @(negedge clk);
    chk("R7 same-cycle request served", wr_n, 3);
    chk("R7 steal final addr", 32'(wlog_a[2]), 32'hB4);
    chk("R7 steal final data", wlog_d[2], {16'd0, smem[5], smem[4]});
    chk("R3 steal done idle", {29'd0, done, busy, pending}, 32'd4);
    chk("R9 auto disable", {31'd0, req_on}, 0);
    auto_off = 0;
  endtask

  task automatic t_req_gate();
    clear_all();
    setmode(2'b10, 2'b10, 1, 1, 0, 1);
    load(32'h40, 32'hD0, 2, 0);
    @(negedge clk); per_req = 1;
    @(negedge clk); per_req = 0;
    repeat (6) @(negedge clk);
    chk("R8 request ignored", {30'd0, busy, pending}, 0);
    chk("R8 request no writes", wr_n, 0);
    kick(); wait_idle();
    chk("R8 start writes", wr_n, 1);
    chk("R8 start done", {31'd0, done}, 1);
    steal_mode = 0;
  endtask

  task automatic t_cfg_err();
    clear_all();
    setmode(2'b00, 2'b00, 1, 1, 0, 0);
    load(32'h02, 32'h80, 8, 0);
    kick(); repeat (3) @(negedge clk);
    chk("R10 misaligned", {29'd0, cfg_err, done, busy}, 32'd6);
    chk("R10 misaligned no bus", rd_n + wr_n, 0);
    clear_all();
    chk("R13 clear", {30'd0, done, cfg_err}, 0);
    src_size = 2'b11;
    load(32'h00, 32'h80, 8, 0);
    kick(); repeat (3) @(negedge clk);
    chk("R10 bad size", {31'd0, cfg_err}, 1);
    clear_all();
    src_size = 2'b00;
    load(32'h0010_0000, 32'h80, 8, 0);
    kick(); repeat (3) @(negedge clk);
    chk("R10 out of range", {31'd0, cfg_err}, 1);
    clear_all();
    load(32'h00, 32'h80, 6, 0);
    kick(); repeat (3) @(negedge clk);
    chk("R10 count multiple", {31'd0, cfg_err}, 1);
    chk("R10 no bus", rd_n + wr_n, 0);
    chk("R3 irq low on error", {31'd0, irq}, 0);
  endtask

  task automatic t_bus_err();
    clear_all();
    setmode(2'b00, 2'b00, 1, 1, 0, 0);
    err_en = 1; err_we = 0; err_addr = 20'h08;
    load(32'h00, 32'hC0, 16, 0);
    kick(); wait_idle(); repeat (3) @(negedge clk);
    chk("R11 src err flags", {29'd0, src_err, dst_err, done}, 32'd5);
    chk("R11 src err writes", wr_n, 2);
    chk("R11 src err left", 32'(bytes_left), 8);
    chk("R11 src err stopped", {30'd0, busy, bus_req}, 0);
    clear_all();
    chk("R13 clear src err", {31'd0, src_err}, 0);
    err_we = 1; err_addr = 20'hC4;
    load(32'h00, 32'hC0, 16, 0);
    kick(); wait_idle(); repeat (3) @(negedge clk);
    chk("R12 dst err flags", {29'd0, src_err, dst_err, done}, 32'd3);
    chk("R12 dst err writes", wr_n, 1);
    chk("R12 dst err left", 32'(bytes_left), 12);
    chk("R12 dst err irq", {31'd0, irq}, 0);
    err_en = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) smem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_word_copy();
    t_unpack();
    t_pack();
    t_fixed_dst();
    t_wrap();
    t_steal();
    t_req_gate();
    t_cfg_err();
    t_bus_err();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nvec++;
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule